// File: doc/BRIEF.md
# Ring-Linked Depth-Cascade FIFO Slice

This block is one slice of a FIFO that can be chained with identical slices into a deeper queue. All slices in a group share the active-low write and read strobes and the input data bus. Their output buses are ORed together into one bus. Each slice's ring-out line feeds the ring-in line of the next slice, and the last slice feeds the first, so the slices form a ring. Two privileges travel around the ring: the write token and the read token. Only the slice holding the write token stores a strobed word, and only the slice holding the read token answers a read. The group therefore behaves as one FIFO of slice-count × DEPTH words, with no added latency at a hand-off.

The slice's role is captured while reset is held low. If its ring-in line is high during reset, it joins a ring. In that case a low lead-select input makes it the leader, which starts with both tokens, and a high input makes it a follower, which starts with none. If its ring-in line is low during reset, it works as a standalone FIFO that keeps both tokens permanently.

A slice hands a token on by pulling ring-out low, combinationally, in the same cycle in which it accepts a write or read of its last location, index DEPTH-1. The next slice takes the token at that clock edge. Hand-offs on any link strictly alternate: write, read, write, and so on. The first hand-off after reset is always a write. The receiver therefore decodes each single-cycle pulse by keeping a one-bit parity of the pulses it has seen.

Top module: `cascade_fifo_slice`

## Requirements
- R1: While reset is low, a slice whose ring-in is high and whose lead-select is low becomes the leader and holds both tokens after reset; a slice with lead-select high holds none. After reset the group shows empty (the AND of empty_n is 0), not full (the AND of full_n is 1), and every dout is all zeros.
- R2: While rst_n is low, ring-out is high, whatever the strobes are.
- R3: Words leave the group in the order they were written, across every token hand-off. A word is accepted on a clock edge where wr_n is low, the slice holds the write token and its own store is not full.
- R4: A ring slice pulls ring-out low, in the same cycle, when it accepts a write into location DEPTH-1. The next slice accepts the very next write, with no idle cycle in between.
- R5: A ring slice pulls ring-out low, in the same cycle, when it accepts a read of location DEPTH-1. Pulses on each link alternate write, read, write, and so on; at most one pulse occurs per cycle.
- R6: A slice's dout is nonzero only in the cycle after a clock edge where it accepted a read; in that cycle it carries the word read. Otherwise dout is all zeros, so the buses of all slices can be ORed.
- R7: The group shows full (the AND of full_n is 0) exactly when slice-count × DEPTH words are unread. A write strobe while full stores nothing.
- R8: The group shows empty exactly when no word is unread. A read strobe while empty drives no word and moves nothing.
- R9: A slice whose ring-in is low during reset works alone with capacity DEPTH: it keeps both tokens, wraps its locations and never pulls ring-out low.
- R10: A write and a read strobed in the same cycle are both accepted when the queue is neither full nor empty. When it is empty, only the write is accepted; when it is full, only the read is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; the role is captured while it is low |
| lead_n | input | 1 | Lead-select, active low, sampled during reset |
| ring_in | input | 1 | Hand-off pulses from the previous slice; its level during reset selects ring or standalone |
| ring_out | output | 1 | Hand-off pulses to the next slice, active low; high during reset |
| wr_n | input | 1 | Write strobe, active low, shared by all slices |
| rd_n | input | 1 | Read strobe, active low, shared by all slices |
| din | input | WIDTH | Write data, shared by all slices |
| dout | output | WIDTH | Read data, all zeros when this slice is not answering a read |
| full_n | output | 1 | Low when this slice holds the write token and its store is full |
| empty_n | output | 1 | Low when this slice holds the read token and its store is empty |

## Verification
The bench builds a ring of three four-deep slices, with the middle one as leader, and places a standalone slice beside it on the same strobes. It checks every link's ring-out in every cycle. A decoder that confused write and read pulses, or a hand-off that cost one cycle, would show up as a missing or misplaced pulse. It would also drop or duplicate a word at the slice boundary. Writes past the twelfth word and reads past the last are strobed deliberately: a design that still accepted them would return an extra word or drive the bus when it should not. Simultaneous strobes at empty and at full catch a design that accepts a read of a word not yet stored. A second reset held with both strobes low catches a ring-out that leaks a pulse during reset or a role that is captured wrongly.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  typedef enum logic { MODE_ALONE = 1'b0, MODE_RING = 1'b1 } ring_mode_e;

  // next location, wrapping at the end of the store
  function automatic int unsigned ptr_step(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // true when the location is the final one of the store
  function automatic logic ptr_at_end(int unsigned p, int unsigned depth);
    return p == depth - 1;
  endfunction

  // a slice starts with the tokens unless it is a ring follower
  function automatic logic starts_with_tokens(logic ring_lvl, logic lead_lvl_n);
    return !(ring_lvl && lead_lvl_n);
  endfunction

  // pick the mode from the ring-in level seen during reset
  function automatic ring_mode_e mode_from_ring(logic ring_lvl);
    return ring_lvl ? MODE_RING : MODE_ALONE;
  endfunction

endpackage

// File: rtl/cfs_store.sv
module cfs_store
  import cfs_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic             rd_fire,
  input  logic [WIDTH-1:0] wdata,
  output logic             wr_at_end,
  output logic             rd_at_end,
  output logic             is_full,
  output logic             is_empty,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;

  assign is_full   = (cnt == CW'(DEPTH));
  assign is_empty  = (cnt == '0);
  assign wr_at_end = ptr_at_end(int'(wptr), DEPTH);
  assign rd_at_end = ptr_at_end(int'(rptr), DEPTH);

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_fire;
      if (wr_fire) wptr <= AW'(ptr_step(int'(wptr), DEPTH));
      if (rd_fire) begin
        rptr  <= AW'(ptr_step(int'(rptr), DEPTH));
        rdata <= mem[rptr];
      end
      case ({wr_fire, rd_fire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7: occupancy never exceeds the store
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R10: a simultaneous write and read leave occupancy unchanged
  a_r10_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> $stable(cnt));
  // R3: a lone write adds exactly one word
  a_r3_write_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !rd_fire) |=> (cnt == CW'($past(cnt) + 1'b1)));

endmodule

// File: rtl/cfs_token.sv
module cfs_token
  import cfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lead_n,
  input  logic ring_in,
  input  logic w_end,
  input  logic r_end,
  output logic has_wtok,
  output logic has_rtok,
  output logic ring_out
);
  ring_mode_e mode;
  logic expect_rd;
  logic w_pass, r_pass, recv, recv_w, recv_r;

  assign w_pass   = (mode == MODE_RING) && w_end;
  assign r_pass   = (mode == MODE_RING) && r_end;
  assign recv     = rst_n && (mode == MODE_RING) && !ring_in;
  assign recv_w   = recv && !expect_rd;
  assign recv_r   = recv && expect_rd;
  assign ring_out = rst_n ? !(w_pass || r_pass) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= mode_from_ring(ring_in);
      has_wtok  <= starts_with_tokens(ring_in, lead_n);
      has_rtok  <= starts_with_tokens(ring_in, lead_n);
      expect_rd <= 1'b0;
    end else begin
      has_wtok <= (has_wtok && !w_pass) || recv_w;
      has_rtok <= (has_rtok && !r_pass) || recv_r;
      if (recv) expect_rd <= !expect_rd;
    end
  end

  // R2: ring-out stays high through reset
  a_r2_reset_high: assert property (@(posedge clk) !rst_n |-> ring_out);
  // R5: never both hand-offs in one cycle
  a_r5_one_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({w_pass, r_pass}));
  // R5: a write hand-off is never followed at once by another write hand-off
  a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    recv_w |=> !recv_w);
  // R4: a passed write token leaves the slice unless it comes straight back
  a_r4_token_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (w_pass && !recv_w) |=> !has_wtok);
  // R9: a standalone slice never pulses
  a_r9_alone_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ALONE) |-> ring_out);

endmodule

// File: rtl/cascade_fifo_slice.sv
module cascade_fifo_slice
  import cfs_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lead_n,
  input  logic             ring_in,
  output logic             ring_out,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full_n,
  output logic             empty_n
);
  logic has_wtok, has_rtok;
  logic wr_fire, rd_fire;
  logic wr_at_end, rd_at_end, is_full, is_empty;
  logic w_end, r_end;
  logic [WIDTH-1:0] rdata;
  logic rvalid;

  assign wr_fire = rst_n && !wr_n && has_wtok && !is_full;
  assign rd_fire = rst_n && !rd_n && has_rtok && !is_empty;
  assign w_end   = wr_fire && wr_at_end;
  assign r_end   = rd_fire && rd_at_end;
  assign full_n  = !(has_wtok && is_full);
  assign empty_n = !(has_rtok && is_empty);
  assign dout    = rvalid ? rdata : '0;

  cfs_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk, .rst_n, .wr_fire, .rd_fire, .wdata(din),
    .wr_at_end, .rd_at_end, .is_full, .is_empty, .rdata, .rvalid
  );

  cfs_token u_token (
    .clk, .rst_n, .lead_n, .ring_in, .w_end, .r_end,
    .has_wtok, .has_rtok, .ring_out
  );

  // R6: the bus carries a word only after an accepted read
  a_r6_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != '0) |-> $past(rd_fire));
  // R8: an empty slice holding the read token answers nothing next cycle
  a_r8_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n) |=> (dout == '0));

endmodule

// File: tb/tb_cascade_fifo_slice.sv
`timescale 1ns/100ps
module tb_cascade_fifo_slice;
  localparam int W = 9, D = 4, N = 3, CAP = N * D, LEAD = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [N-1:0] xo, fulln, emptyn;
  logic [W-1:0] part [N];
  logic sa_xo, sa_full_n, sa_empty_n;
  logic [W-1:0] sa_dout;

  int tests = 0, failed = 0, wtot = 0, rtot = 0;
  logic [W-1:0] rq[$];
  logic [W-1:0] sq[$];

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : ring
    cascade_fifo_slice #(.WIDTH(W), .DEPTH(D)) dut (
      .clk, .rst_n, .lead_n(g == LEAD ? 1'b0 : 1'b1),
      .ring_in(xo[(g + N - 1) % N]), .ring_out(xo[g]),
      .wr_n, .rd_n, .din, .dout(part[g]),
      .full_n(fulln[g]), .empty_n(emptyn[g])
    );
  end

  cascade_fifo_slice #(.WIDTH(W), .DEPTH(D)) dut_alone (
    .clk, .rst_n, .lead_n(1'b0), .ring_in(1'b0), .ring_out(sa_xo),
    .wr_n, .rd_n, .din, .dout(sa_dout),
    .full_n(sa_full_n), .empty_n(sa_empty_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [W-1:0] d);
    logic aw, ar, saw, sar;
    logic [N-1:0] exp_x;
    logic [W-1:0] v, sv;
    int rsl;
    @(negedge clk);
    wr_n = !w; rd_n = !r; din = d;
    aw  = w && (rq.size() < CAP);
    ar  = r && (rq.size() > 0);
    saw = w && (sq.size() < D);
    sar = r && (sq.size() > 0);
    exp_x = '1;
    if (aw && (wtot % D == D - 1)) exp_x[(LEAD + wtot / D) % N] = 1'b0;
    if (ar && (rtot % D == D - 1)) exp_x[(LEAD + rtot / D) % N] = 1'b0;
    rsl = (LEAD + rtot / D) % N;
    #1;
    chk("R4 R5 hand-off pulses", 32'(xo), 32'(exp_x));
    chk("R9 standalone ring_out", 32'(sa_xo), 32'd1);
    @(posedge clk); #1;
    v = '0; sv = '0;
    if (ar) begin v = rq.pop_front(); rtot++; end
    if (aw) begin rq.push_back(d); wtot++; end
    if (sar) sv = sq.pop_front();
    if (saw) sq.push_back(d);
    for (int i = 0; i < N; i++)
      chk("R3 R6 slice bus", 32'(part[i]), (ar && i == rsl) ? 32'(v) : 32'd0);
    chk("R7 group full", 32'(&fulln), (rq.size() == CAP) ? 32'd0 : 32'd1);
    chk("R8 group empty", 32'(&emptyn), (rq.size() == 0) ? 32'd0 : 32'd1);
    chk("R9 standalone data", 32'(sa_dout), 32'(sv));
    chk("R9 standalone full", 32'(sa_full_n), (sq.size() == D) ? 32'd0 : 32'd1);
    chk("R9 standalone empty", 32'(sa_empty_n), (sq.size() == 0) ? 32'd0 : 32'd1);
  endtask

  task automatic do_reset(input logic wlvl, input logic rlvl);
    @(negedge clk);
    rst_n = 1'b0; wr_n = wlvl; rd_n = rlvl;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R2 ring_out high in reset", 32'({xo, sa_xo}), 32'hF);
    end
    @(negedge clk);
    rst_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    rq.delete(); sq.delete(); wtot = 0; rtot = 0;
    @(posedge clk); #1;
    chk("R1 empty after reset", 32'(&emptyn), 32'd0);
    chk("R1 not full after reset", 32'(&fulln), 32'd1);
    chk("R1 bus idle after reset", 32'(part[0] | part[1] | part[2] | sa_dout), 32'd0);
    chk("R1 follower flags quiet", 32'({emptyn[0], emptyn[2], fulln}), 32'h1F);
  endtask

  // {write, read, data}
  localparam logic [W+1:0] VEC [16] = '{
    {2'b10, 9'h101}, {2'b10, 9'h0A2}, {2'b10, 9'h0C3}, {2'b01, 9'h000},
    {2'b10, 9'h1E4}, {2'b10, 9'h0F5}, {2'b11, 9'h1A6}, {2'b11, 9'h0B7},
    {2'b01, 9'h000}, {2'b01, 9'h000}, {2'b10, 9'h0D8}, {2'b10, 9'h1C9},
    {2'b01, 9'h000}, {2'b00, 9'h000}, {2'b11, 9'h0EA}, {2'b01, 9'h000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    tests++; failed++;
    $display("FAIL watchdog expired before the run ended");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    do_reset(1'b1, 1'b1);
    // R3 R10: table of mixed patterns
    for (int k = 0; k < 16; k++) step(VEC[k][W+1], VEC[k][W], VEC[k][W-1:0]);
    // drain what the table left
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, '0);
    // R10: both strobes while empty, only the write lands
    step(1'b1, 1'b1, 9'h155);
    step(1'b0, 1'b1, '0);
    // R7: fill beyond capacity, extra writes ignored
    for (int k = 0; k < CAP + 2; k++) step(1'b1, 1'b0, W'(k * 37 + 5));
    // R10: both strobes while full, only the read lands
    step(1'b1, 1'b1, 9'h1FF);
    // R8: drain beyond empty, extra reads ignored
    for (int k = 0; k < CAP + 2; k++) step(1'b0, 1'b1, '0);
    // R4 R5: streaming with both strobes around the ring several times
    for (int k = 0; k < 60; k++) step(k % 3 != 2, k % 2 == 0, W'(k * 11 + 3));
    for (int k = 0; k < CAP; k++) step(1'b0, 1'b1, '0);
    // R1 R2: reset while strobes are low, then roles restart at the leader
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 10; k++) step(1'b1, 1'b0, W'(k + 9'h40));
    for (int k = 0; k < 11; k++) step(1'b0, 1'b1, '0);
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule